// File: doc/BRIEF.md
# Four-Bank Interleaved Cache Line Fill Controller

This block fetches one 4-word (16-byte) cache line from a memory split across four word-wide banks. The word offset inside the line (byte address bits 3:2) decides which bank holds a word. The line address (bits 31:4) goes to every bank at the same time. In interleaved operation a single address cycle starts all four banks together. After the common array delay the four words leave over a 32-bit bus, one per clock, lowest offset first.

A mode input replaces the interleaved timing with that of a single narrow memory. The banks are then used strictly one after another, and the address advances by itself after each word. The same line can therefore be fetched under both schemes and the cycle counts compared. The banks are behavioural: each one returns its word a fixed number of clocks after it is started. The content of a word is a fixed function of its word address.

Top module: `ilfLineFill`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `wordValid` and `lineDone` are low.
- R2: A request (`reqValid` high) is accepted on a rising edge only while `busy` is low. `busy` is high from the cycle after that edge up to and including the `lineDone` cycle. It is low in the cycle that follows.
- R3: A request or address change presented while `busy` is high has no effect on the line in progress. A request still held in the `lineDone` cycle is accepted on the edge that ends the following idle cycle.
- R4: The word returned with index k comes from byte address {reqAddr[31:4], k, 2'b00}. Bits 3:0 of `reqAddr` do not change the data. The word at word address W = A[31:2] holds (W × 0x9E3779B1) xor 0xA5A50F0F, truncated to 32 bits.
- R5: The words of a line are delivered in ascending offset order. `wordIdx` carries the offset, 0 to 3.
- R6: In interleaved mode (`narrowMode` = 0), counting the accepting edge as cycle 0, `wordValid` is high in cycles 17 to 20 and low in all other cycles. That is 1 address clock, 15 access clocks and 4 transfer clocks.
- R7: In narrow mode (`narrowMode` = 1), word k is valid only in cycle 17 + 16·k, and `wordValid` is low in every other cycle. `lineDone` falls in cycle 65 (1 + 4·15 + 4·1). Only one bank access is in flight at a time.
- R8: `lineDone` is high for exactly one cycle per line, in the cycle of the word with index 3.
- R9: `narrowMode` is sampled only at acceptance. Changing it during a line does not alter that line's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Line fill request |
| reqAddr | input | 32 | Byte address inside the requested line |
| narrowMode | input | 1 | 1 selects single narrow bank timing |
| busy | output | 1 | A line fill is in progress |
| wordValid | output | 1 | A word is on `wordData` this cycle |
| wordIdx | output | 2 | Offset of the word within the line |
| wordData | output | 32 | Returned word |
| lineDone | output | 1 | Last word of the line is being delivered |

## Verification
The two functions that can meet in one cycle are the delivery of the final word with `lineDone`, and a new request arriving. The bench provokes this by holding `reqValid` high with a different address from acceptance through the end of the line. It then judges three things: that the first line still returns the data of its own address, that `busy` drops for exactly one cycle, and that the second line then runs with full latency and returns the new address's words. In a separate sweep, `narrowMode` is flipped in the middle of a line to show that the timing was fixed at acceptance.

// File: rtl/ilfPkg.sv
package ilfPkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int OFF_W     = 2;
  localparam int ROW_W     = ADDR_W - BANK_W - OFF_W;
  localparam int WADDR_W   = ADDR_W - OFF_W;
  localparam logic [DATA_W-1:0] HASH_MUL = 32'h9E3779B1;
  localparam logic [DATA_W-1:0] HASH_XOR = 32'hA5A50F0F;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT, ST_XFER} fillState_t;

  typedef struct packed {
    logic                 capture;
    logic [NUM_BANKS-1:0] bankStart;
    logic                 xferEn;
    logic [BANK_W-1:0]    xferIdx;
  } fillStrobe_t;

  function automatic logic [DATA_W-1:0] memWord(input logic [WADDR_W-1:0] w);
    logic [DATA_W-1:0] prod;
    prod = DATA_W'(w) * HASH_MUL;
    return prod ^ HASH_XOR;
  endfunction
endpackage

// File: rtl/ilfBank.sv
module ilfBank
  import ilfPkg::*;
#(
  parameter int LATENCY = 15,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ROW_W-1:0]  rowAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdReady
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] latCnt;
  logic [ROW_W-1:0] rowReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt  <= '0;
      rowReg  <= '0;
      rdData  <= '0;
      rdReady <= 1'b0;
    end else if (start) begin
      rowReg  <= rowAddr;
      latCnt  <= CNT_W'(LATENCY);
      rdReady <= 1'b0;
    end else if (latCnt != '0) begin
      latCnt <= latCnt - 1'b1;
      if (latCnt == CNT_W'(1)) begin
        rdReady <= 1'b1;
        rdData  <= memWord({rowReg, BANK_W'(BANK_ID)});
      end
    end
  end

  AST_BANK_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (latCnt == '0)); // R7
endmodule

// File: rtl/ilfCtrl.sv
module ilfCtrl
  import ilfPkg::*;
#(
  parameter int ACCESS_CYC = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        narrowMode,
  output fillStrobe_t strb,
  output logic        busy,
  output logic        lineDone
);
  localparam int WAIT_W = $clog2(ACCESS_CYC + 1);
  localparam logic [BANK_W-1:0] LAST_IDX = BANK_W'(NUM_BANKS - 1);

  fillState_t        state;
  logic [WAIT_W-1:0] waitCnt;
  logic [BANK_W-1:0] idxCnt;
  logic              narrowReg;

  always_comb begin
    strb = '0;
    strb.capture = (state == ST_IDLE) && reqValid;
    case (state)
      ST_ADDR: begin
        for (int b = 0; b < NUM_BANKS; b++)
          strb.bankStart[b] = narrowReg ? (b == 0) : 1'b1;
      end
      ST_XFER: begin
        strb.xferEn  = 1'b1;
        strb.xferIdx = idxCnt;
        for (int b = 0; b < NUM_BANKS; b++)
          strb.bankStart[b] = narrowReg && (idxCnt != LAST_IDX) &&
                              (b == int'(idxCnt) + 1);
      end
      default: ;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign lineDone = (state == ST_XFER) && (idxCnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      idxCnt    <= '0;
      narrowReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state     <= ST_ADDR;
          narrowReg <= narrowMode;
          idxCnt    <= '0;
        end
        ST_ADDR: begin
          state   <= ST_WAIT;
          waitCnt <= WAIT_W'(ACCESS_CYC - 1);
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_XFER;
          else waitCnt <= waitCnt - 1'b1;
        end
        ST_XFER: begin
          if (idxCnt == LAST_IDX) begin
            state <= ST_IDLE;
          end else begin
            idxCnt <= idxCnt + 1'b1;
            if (narrowReg) begin
              state   <= ST_WAIT;
              waitCnt <= WAIT_W'(ACCESS_CYC - 1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (strb.xferEn && strb.xferIdx == LAST_IDX)); // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !busy); // R2
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lineDone) |=> busy); // R2
  AST_NARROW_ONE_START: assert property (@(posedge clk) disable iff (!rstN)
    narrowReg |-> ($countones(strb.bankStart) <= 1)); // R7
  AST_WIDE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferEn && !lineDone && !narrowReg) |=>
      (strb.xferEn && strb.xferIdx == BANK_W'($past(strb.xferIdx) + 1'b1))); // R5
endmodule

// File: rtl/ilfDatapath.sv
module ilfDatapath
  import ilfPkg::*;
#(
  parameter int ACCESS_CYC = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  fillStrobe_t       strb,
  output logic              wordValid,
  output logic [BANK_W-1:0] wordIdx,
  output logic [DATA_W-1:0] wordData
);
  logic [ROW_W-1:0]  rowReg;
  logic [DATA_W-1:0] bankData  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankReady;
  logic unusedLowBits;

  assign unusedLowBits = ^reqAddr[BANK_W+OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) rowReg <= '0;
    else if (strb.capture) rowReg <= reqAddr[ADDR_W-1:BANK_W+OFF_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    ilfBank #(.LATENCY(ACCESS_CYC), .BANK_ID(b)) uBank (
      .clk     (clk),
      .rstN    (rstN),
      .start   (strb.bankStart[b]),
      .rowAddr (rowReg),
      .rdData  (bankData[b]),
      .rdReady (bankReady[b])
    );
  end

  assign wordValid = strb.xferEn;
  assign wordIdx   = strb.xferIdx;
  assign wordData  = strb.xferEn ? bankData[strb.xferIdx] : '0;

  AST_XFER_DATA_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferEn |-> bankReady[strb.xferIdx]); // R6
endmodule

// File: rtl/ilfLineFill.sv
module ilfLineFill
  import ilfPkg::*;
#(
  parameter int ACCESS_CYC = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        narrowMode,
  output logic        busy,
  output logic        wordValid,
  output logic [1:0]  wordIdx,
  output logic [31:0] wordData,
  output logic        lineDone
);
  fillStrobe_t strb;

  ilfCtrl #(.ACCESS_CYC(ACCESS_CYC)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .narrowMode (narrowMode),
    .strb       (strb),
    .busy       (busy),
    .lineDone   (lineDone)
  );

  ilfDatapath #(.ACCESS_CYC(ACCESS_CYC)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .strb      (strb),
    .wordValid (wordValid),
    .wordIdx   (wordIdx),
    .wordData  (wordData)
  );
endmodule

// File: tb/ilfLineFill_bench.sv
`timescale 1ns/1ps
module ilfLineFill_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        narrowMode;
  logic        busy, wordValid, lineDone;
  logic [1:0]  wordIdx;
  logic [31:0] wordData;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  ilfLineFill u_ilfLineFill (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .narrowMode(narrowMode), .busy(busy), .wordValid(wordValid),
    .wordIdx(wordIdx), .wordData(wordData), .lineDone(lineDone)
  );

  function automatic logic [31:0] refWord(input logic [29:0] w);
    logic [31:0] m;
    m = {2'b00, w} * 32'h9E3779B1;
    return m ^ 32'hA5A50F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic startLine(input logic [31:0] a, input logic m);
    reqValid   = 1'b1;
    reqAddr    = a;
    narrowMode = m;
    @(posedge clk);
  endtask

  // Called right after the accepting edge; ends at the negedge of the idle cycle.
  task automatic collect(input logic [31:0] a, input logic m, input bit flip,
                         input bit hold, input logic [31:0] alt);
    int last;
    last = m ? 65 : 20;
    for (int cyc = 1; cyc <= last + 1; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        if (hold) reqAddr = alt;
        else reqValid = 1'b0;
      end
      if (flip && cyc == 5) narrowMode = ~m;
      if (cyc <= last) begin
        bit expV;
        int k;
        expV = m ? (cyc >= 17 && ((cyc - 17) % 16) == 0) : (cyc >= 17);
        k    = m ? (cyc - 17) / 16 : cyc - 17;
        check(busy === 1'b1, "R2", "busy during line", {31'd0, busy}, 32'd1);
        check(wordValid === expV, flip ? "R9" : (m ? "R7" : "R6"),
              "wordValid timing", {31'd0, wordValid}, {31'd0, expV});
        check(lineDone === (cyc == last), "R8", "lineDone timing",
              {31'd0, lineDone}, {31'd0, (cyc == last)});
        if (expV) begin
          check(wordIdx === k[1:0], "R5", "word order", {30'd0, wordIdx}, {30'd0, k[1:0]});
          check(wordData === refWord({a[31:4], k[1:0]}), hold ? "R3" : "R4",
                "word data", wordData, refWord({a[31:4], k[1:0]}));
        end
      end else begin
        check(busy === 1'b0, hold ? "R3" : "R2", "idle after lineDone",
              {31'd0, busy}, 32'd0);
      end
    end
  endtask

  logic [31:0] addrs [6];

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    addrs[0] = 32'h0000_0000;
    addrs[1] = 32'h0000_0010;
    addrs[2] = 32'h4000_0004;
    addrs[3] = 32'hFFFF_FFF3;
    addrs[4] = 32'h1234_567B;
    addrs[5] = 32'h8000_000E;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; narrowMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && wordValid === 1'b0 && lineDone === 1'b0, "R1",
          "outputs in reset", {29'd0, busy, wordValid, lineDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && wordValid === 1'b0 && lineDone === 1'b0, "R1",
          "outputs after reset", {29'd0, busy, wordValid, lineDone}, 32'd0);

    for (int mi = 0; mi < 2; mi++) begin
      for (int ai = 0; ai < 6; ai++) begin
        startLine(addrs[ai], mi[0]);
        collect(addrs[ai], mi[0], (ai == 2 || ai == 5), 1'b0, '0);
      end
    end

    // R3: request held through lineDone with a different address
    for (int mi = 0; mi < 2; mi++) begin
      startLine(32'h0ABC_DE04, mi[0]);
      collect(32'h0ABC_DE04, mi[0], 1'b0, 1'b1, 32'h7654_3218);
      @(posedge clk);
      collect(32'h7654_3218, mi[0], 1'b0, 1'b0, '0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule